// File: doc/BRIEF.md
# Return Address Stack Controller

This block holds the return addresses of nested subroutine calls for a processor with a 15-bit program counter. When a call strobe arrives and its condition holds, the address of the instruction after the call is written into an eight-entry stack and the next PC becomes the call target. When a return strobe arrives and its condition holds, the newest entry is taken back off the stack and becomes the next PC. In every other case the PC moves past the instruction. The result is registered and appears one clock after the strobe.

The 3-bit stack pointer and an interrupt-inhibit bit live in an 8-bit upper status byte. Software can read this byte at the outputs and write it through a load strobe. A call or return is conditional on a 2-bit condition field, which is compared with the processor's current 2-bit condition code. An invert input selects the "taken when different" form. A return variant also clears the interrupt-inhibit bit. Instruction decode and program memory sit outside the block.

Top module: `ras_ctrl`

## Requirements
- R1: After reset `sp_o` is 0, `status_o` is 0x00, `taken_o` is 0, and `next_pc_o` and `ret_addr_o` are 0.
- R2: A taken call writes PC+3 (`long_i`=1) or PC+2 (`long_i`=0), modulo 2^15, into the entry selected by the current pointer. The pointer then increments. One cycle later `next_pc_o` equals `target_i` and `taken_o` is 1.
- R3: A taken return first decrements the pointer and then reads that entry. One cycle later both `ret_addr_o` and `next_pc_o` hold the entry and `taken_o` is 1.
- R4: The condition holds when `cond_i` is 3. Otherwise it holds when (`cond_i`==`cc_i`) XOR `invert_i` is 1.
- R5: A call or return whose condition fails leaves the pointer and the stack unchanged. It drives `taken_o` to 0 and `next_pc_o` to PC+2 or PC+3 according to `long_i`.
- R6: A taken return with `ret_ie_i`=1 clears the interrupt-inhibit bit (bit 5 of `status_o`). When the condition fails, the bit keeps its value.
- R7: The pointer wraps modulo 8 with no error indication. A ninth push overwrites the oldest entry, and a pop at pointer 0 reads entry 7.
- R8: `status_o` carries the pointer in bits 2:0 and the interrupt-inhibit bit in bit 5; all other bits are 0. When `stat_wr_i` is 1 with no strobe, both fields load from `stat_i`.
- R9: When `call_i` and `ret_i` are both 1, only the call is performed. A status load in the same cycle as any strobe is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| call_i | input | 1 | Call strobe |
| ret_i | input | 1 | Return strobe |
| long_i | input | 1 | Instruction is 3 bytes (1) or 2 bytes (0) |
| invert_i | input | 1 | Taken when condition field differs from code |
| ret_ie_i | input | 1 | Return also clears interrupt inhibit |
| cond_i | input | 2 | Condition field, 3 = always |
| cc_i | input | 2 | Current condition code |
| pc_i | input | 15 | Address of the current instruction |
| target_i | input | 15 | Call destination |
| stat_wr_i | input | 1 | Load the upper status byte |
| stat_i | input | 8 | Upper status byte to load |
| taken_o | output | 1 | Last strobe was taken |
| next_pc_o | output | 15 | PC after the last operation |
| ret_addr_o | output | 15 | Last address popped |
| sp_o | output | 3 | Stack pointer |
| status_o | output | 8 | Upper status byte |

## Verification
The assertions assume that each strobe lasts one cycle and that the condition inputs are valid while a strobe is high. The pop checks treat a return as meaningful only when no call accompanies it. The bench drives every operation in a cycle of its own, with settled inputs, from the falling edge. It enters the both-strobes case only on purpose, to exercise the precedence rule. Pops read only entries that an earlier push wrote, so no expected value depends on unwritten storage.

// File: rtl/ras_pkg.sv
package ras_pkg;
    // Bit positions inside the upper status byte
    localparam int IIB_POS   = 5;
    // Condition field encoding meaning "always"
    localparam logic [1:0] COND_ALWAYS = 2'b11;
    // Instruction lengths in bytes
    localparam int LEN_SHORT = 2;
    localparam int LEN_LONG  = 3;
endpackage

// File: rtl/ras_cond.sv
module ras_cond #(
    parameter int CC_W = 2
) (
    input  logic [CC_W-1:0] field_i,
    input  logic [CC_W-1:0] code_i,
    input  logic            invert_i,
    output logic            take_o
);
    import ras_pkg::*;

    logic match;

    always_comb begin
        match  = (field_i == code_i);
        take_o = (field_i == CC_W'(COND_ALWAYS)) || (match ^ invert_i);
    end
endmodule

// File: rtl/ras_store.sv
module ras_store #(
    parameter int AW = 3,
    parameter int DW = 15
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (we_i && (waddr_i == AW'(g))) begin
                mem_q[g] <= wdata_i;
            end
        end
    end

    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/ras_ctrl.sv
module ras_ctrl #(
    parameter int PC_W   = 15,
    parameter int SP_W   = 3,
    parameter int CC_W   = 2,
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              call_i,
    input  logic              ret_i,
    input  logic              long_i,
    input  logic              invert_i,
    input  logic              ret_ie_i,
    input  logic [CC_W-1:0]   cond_i,
    input  logic [CC_W-1:0]   cc_i,
    input  logic [PC_W-1:0]   pc_i,
    input  logic [PC_W-1:0]   target_i,
    input  logic              stat_wr_i,
    input  logic [STAT_W-1:0] stat_i,
    output logic              taken_o,
    output logic [PC_W-1:0]   next_pc_o,
    output logic [PC_W-1:0]   ret_addr_o,
    output logic [SP_W-1:0]   sp_o,
    output logic [STAT_W-1:0] status_o
);
    import ras_pkg::*;

    typedef struct packed {
        logic [SP_W-1:0] sp;
        logic            ii;
        logic            taken;
        logic [PC_W-1:0] ret_addr;
        logic [PC_W-1:0] next_pc;
    } state_t;

    state_t st_d, st_q;

    logic            take_w;
    logic [PC_W-1:0] step_w;
    logic [PC_W-1:0] seq_pc_w;
    logic            push_we_d;
    logic [SP_W-1:0] pop_idx_d;
    logic [PC_W-1:0] pop_data_w;
    logic [SP_W-1:0] sp_q;

    assign sp_q = st_q.sp;

    ras_cond #(.CC_W(CC_W)) i_cond (
        .field_i  (cond_i),
        .code_i   (cc_i),
        .invert_i (invert_i),
        .take_o   (take_w)
    );

    ras_store #(.AW(SP_W), .DW(PC_W)) i_store (
        .clk     (clk),
        .we_i    (push_we_d),
        .waddr_i (sp_q),
        .wdata_i (seq_pc_w),
        .raddr_i (pop_idx_d),
        .rdata_o (pop_data_w)
    );

    always_comb begin
        step_w    = long_i ? PC_W'(LEN_LONG) : PC_W'(LEN_SHORT);
        seq_pc_w  = pc_i + step_w;
        pop_idx_d = sp_q - SP_W'(1);
        push_we_d = 1'b0;
        st_d       = st_q;
        st_d.taken = 1'b0;
        if (call_i) begin
            if (take_w) begin
                push_we_d    = 1'b1;
                st_d.sp      = sp_q + SP_W'(1);
                st_d.next_pc = target_i;
                st_d.taken   = 1'b1;
            end else begin
                st_d.next_pc = seq_pc_w;
            end
        end else if (ret_i) begin
            if (take_w) begin
                st_d.sp       = pop_idx_d;
                st_d.ret_addr = pop_data_w;
                st_d.next_pc  = pop_data_w;
                st_d.taken    = 1'b1;
                if (ret_ie_i) begin
                    st_d.ii = 1'b0;
                end
            end else begin
                st_d.next_pc = seq_pc_w;
            end
        end else if (stat_wr_i) begin
            st_d.sp = stat_i[SP_W-1:0];
            st_d.ii = stat_i[IIB_POS];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        status_o             = '0;
        status_o[SP_W-1:0]   = st_q.sp;
        status_o[IIB_POS]    = st_q.ii;
    end

    assign taken_o    = st_q.taken;
    assign next_pc_o  = st_q.next_pc;
    assign ret_addr_o = st_q.ret_addr;
    assign sp_o       = st_q.sp;

    // Pointer steps up by one after a taken call
    assert_push_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && take_w) |=> ((sp_o - $past(sp_o)) == SP_W'(1)) && taken_o);

    // Pointer steps down and the popped word drives the next PC
    assert_pop_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && !call_i && take_w) |=> (($past(sp_o) - sp_o) == SP_W'(1)) && (next_pc_o == ret_addr_o));

    // Failed condition leaves the pointer alone
    assert_untaken_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((call_i || ret_i) && !take_w) |=> $stable(sp_o) && !taken_o);

    // Enabling return clears the inhibit bit
    assert_ie_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && !call_i && take_w && ret_ie_i) |=> !status_o[IIB_POS]);

    // Full pointer rolls over to zero on a push
    assert_wrap_push_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && take_w && (sp_o == '1)) |=> (sp_o == '0));

    // A call beside a return changes only by the push rule
    assert_call_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && ret_i && take_w) |=> (next_pc_o == $past(target_i)));
endmodule

// File: tb/test_ras_ctrl.sv
module test_ras_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        call_i = 0, ret_i = 0, long_i = 0, invert_i = 0, ret_ie_i = 0;
    logic [1:0]  cond_i = 0, cc_i = 0;
    logic [14:0] pc_i = 0, target_i = 0;
    logic        stat_wr_i = 0;
    logic [7:0]  stat_i = 0;
    logic        taken_o;
    logic [14:0] next_pc_o, ret_addr_o;
    logic [2:0]  sp_o;
    logic [7:0]  status_o;

    always #2.5 clk = ~clk;

    ras_ctrl i_ras_ctrl (
        .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i), .long_i(long_i),
        .invert_i(invert_i), .ret_ie_i(ret_ie_i), .cond_i(cond_i), .cc_i(cc_i),
        .pc_i(pc_i), .target_i(target_i), .stat_wr_i(stat_wr_i), .stat_i(stat_i),
        .taken_o(taken_o), .next_pc_o(next_pc_o), .ret_addr_o(ret_addr_o),
        .sp_o(sp_o), .status_o(status_o)
    );

    typedef struct {
        logic        tk;
        logic [14:0] npc;
        logic [14:0] ra;
        logic [2:0]  sp;
        logic [7:0]  st;
        string       tag;
    } exp_t;

    exp_t        sbq[$];
    int          n_chk = 0, n_err = 0;
    bit          done = 0;
    logic [2:0]  m_sp = 0;
    logic        m_ii = 0;
    logic        m_tk = 0;
    logic [14:0] m_npc = 0, m_ra = 0;
    logic [14:0] m_stk [8];

    function automatic logic [7:0] stat_of(input logic [2:0] s, input logic i);
        return {2'b00, i, 2'b00, s};
    endfunction

    // One cycle of stimulus; model the expected outputs from the requirements
    task automatic op(input bit c, input bit r, input bit lg, input bit inv, input bit ie,
                      input logic [1:0] cnd, input logic [1:0] cc,
                      input logic [14:0] pc, input logic [14:0] tgt,
                      input bit wr, input logic [7:0] wd, input string tag);
        exp_t e;
        logic [14:0] seq;
        bit tk;
        @(negedge clk);
        call_i = c; ret_i = r; long_i = lg; invert_i = inv; ret_ie_i = ie;
        cond_i = cnd; cc_i = cc; pc_i = pc; target_i = tgt; stat_wr_i = wr; stat_i = wd;
        seq = pc + (lg ? 15'd3 : 15'd2);
        tk  = (cnd == 2'd3) || ((cnd == cc) ^ inv);
        m_tk = 0;
        if (c) begin
            if (tk) begin m_stk[m_sp] = seq; m_sp = m_sp + 3'd1; m_npc = tgt; m_tk = 1; end
            else m_npc = seq;
        end else if (r) begin
            if (tk) begin
                m_sp = m_sp - 3'd1; m_ra = m_stk[m_sp]; m_npc = m_ra; m_tk = 1;
                if (ie) m_ii = 0;
            end else m_npc = seq;
        end else if (wr) begin
            m_sp = wd[2:0]; m_ii = wd[5];
        end
        e.tk = m_tk; e.npc = m_npc; e.ra = m_ra; e.sp = m_sp; e.st = stat_of(m_sp, m_ii); e.tag = tag;
        #1 sbq.push_back(e);
    endtask

    task automatic idle();
        op(0, 0, 0, 0, 0, 2'd0, 2'd0, 15'd0, 15'd0, 0, 8'd0, "R5");
    endtask

    // Monitor: compare the registered outputs one falling edge after each push
    initial begin
        forever begin
            @(negedge clk);
            if (sbq.size() > 0) begin
                exp_t e;
                e = sbq.pop_front();
                n_chk++;
                if (taken_o !== e.tk || next_pc_o !== e.npc || ret_addr_o !== e.ra ||
                    sp_o !== e.sp || status_o !== e.st) begin
                    n_err++;
                    $display("FAIL %s: got tk=%0b npc=%h ra=%h sp=%0d st=%h, expected tk=%0b npc=%h ra=%h sp=%0d st=%h",
                             e.tag, taken_o, next_pc_o, ret_addr_o, sp_o, status_o,
                             e.tk, e.npc, e.ra, e.sp, e.st);
                end
            end
        end
    end

    initial begin
        #100000;
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        n_chk++;
        if (taken_o !== 0 || next_pc_o !== 0 || ret_addr_o !== 0 || sp_o !== 0 || status_o !== 8'h00) begin
            n_err++;
            $display("FAIL R1: got tk=%0b npc=%h ra=%h sp=%0d st=%h, expected all 0",
                     taken_o, next_pc_o, ret_addr_o, sp_o, status_o);
        end
        // R8 status load, set inhibit and pointer
        op(0, 0, 0, 0, 0, 2'd0, 2'd0, 15'd0, 15'd0, 1, 8'hE2, "R8");
        op(0, 0, 0, 0, 0, 2'd0, 2'd0, 15'd0, 15'd0, 1, 8'h20, "R8");
        // R2 nested unconditional calls, long and short, plus PC wrap
        op(1, 0, 1, 0, 0, 2'd3, 2'd0, 15'h0100, 15'h2000, 0, 8'd0, "R2");
        op(1, 0, 0, 0, 0, 2'd3, 2'd1, 15'h2010, 15'h3000, 0, 8'd0, "R2");
        op(1, 0, 1, 0, 0, 2'd3, 2'd2, 15'h7FFF, 15'h4000, 0, 8'd0, "R2");
        // R3 returns in reverse order
        op(0, 1, 0, 0, 0, 2'd3, 2'd0, 15'h4005, 15'd0, 0, 8'd0, "R3");
        idle();
        // R6 untaken enabling return keeps inhibit
        op(0, 1, 0, 0, 1, 2'd1, 2'd2, 15'h3007, 15'd0, 0, 8'd0, "R6");
        // R6 taken enabling return clears inhibit
        op(0, 1, 1, 0, 1, 2'd2, 2'd2, 15'h3009, 15'd0, 0, 8'd0, "R6");
        op(0, 1, 0, 0, 0, 2'd3, 2'd0, 15'h2100, 15'd0, 0, 8'd0, "R3");
        // R4 condition forms with cc=1
        op(1, 0, 0, 0, 0, 2'd1, 2'd1, 15'h0500, 15'h0600, 0, 8'd0, "R4");
        op(1, 0, 1, 0, 0, 2'd2, 2'd1, 15'h0610, 15'h0700, 0, 8'd0, "R4");
        op(1, 0, 0, 1, 0, 2'd2, 2'd1, 15'h0620, 15'h0800, 0, 8'd0, "R4");
        op(1, 0, 1, 1, 0, 2'd1, 2'd1, 15'h0810, 15'h0900, 0, 8'd0, "R4");
        op(1, 0, 0, 1, 0, 2'd3, 2'd3, 15'h0820, 15'h0A00, 0, 8'd0, "R4");
        // R5 untaken return
        op(0, 1, 1, 0, 0, 2'd0, 2'd3, 15'h0A10, 15'd0, 0, 8'd0, "R5");
        // R9 both strobes and a status load together
        op(1, 1, 1, 0, 1, 2'd3, 2'd0, 15'h0B00, 15'h0C00, 1, 8'h07, "R9");
        op(0, 1, 0, 0, 0, 2'd0, 2'd0, 15'h0C00, 15'd0, 1, 8'h05, "R9");
        // R7 wrap: nine pushes then nine pops
        op(0, 0, 0, 0, 0, 2'd0, 2'd0, 15'd0, 15'd0, 1, 8'h00, "R8");
        for (int k = 0; k < 9; k++)
            op(1, 0, k[0], 0, 0, 2'd3, 2'd0, 15'(16'h1000 + k * 16'h10), 15'(16'h5000 + k), 0, 8'd0, "R7");
        for (int k = 0; k < 9; k++)
            op(0, 1, 0, 0, 0, 2'd3, 2'd0, 15'h6000, 15'd0, 0, 8'd0, "R7");
        // R8 pointer load then pop reads entry below it
        op(0, 0, 0, 0, 0, 2'd0, 2'd0, 15'd0, 15'd0, 1, 8'h25, "R8");
        op(0, 1, 0, 0, 1, 2'd0, 2'd0, 15'h0000, 15'd0, 0, 8'd0, "R8");
        idle();
        repeat (3) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end
endmodule